// File: doc/BRIEF.md
# Wishbone Burst Address Initiator

This block is a bus initiator that turns one user command into a Wishbone transaction. A transaction is either a single classic transfer or a registered-feedback incrementing burst. The command gives a start word address, a beat count, a burst wrap mode, the direction and the byte lanes. For writes, the block asks the user for each beat's data through a beat index. For reads, it returns every acknowledged beat on a one-cycle valid strobe. The block produces each following word address itself from the wrap mode, and it closes the transaction on its own after the final acknowledged beat.

The controlling state machine has four states. IDLE means no transaction is open. CLASSIC holds a single transfer. INCR holds a burst beat that will be followed by another. FINAL holds the last beat of a burst. The transitions are as follows:
- IDLE to CLASSIC is taken when a command arrives with a beat count of 0 or 1.
- IDLE to INCR is taken when a command arrives with a beat count of 2 or more.
- INCR to INCR is taken on an acknowledge while more than two beats remain.
- INCR to FINAL is taken on an acknowledge when exactly two beats remain.
- CLASSIC to IDLE and FINAL to IDLE are taken on the acknowledge of the transfer.

Top module: `wbb_burst_initiator`

## Requirements
- R1: After reset, wb_cyc_o, wb_stb_o, busy, done and rd_valid are all low.
- R2: A command is accepted only while busy is low. In the cycle after acceptance, wb_cyc_o, wb_stb_o and busy are high and wb_adr_o equals cmd_addr. A cmd_valid raised while busy is high has no effect, and no extra transfer follows.
- R3: While a beat is presented and not acknowledged, wb_adr_o, wb_we_o, wb_dat_o, wb_sel_o, wb_cti_o and wb_bte_o keep their values from the previous cycle.
- R4: The cycle-type output is coded as follows: a single transfer drives 3'b000; every burst beat except the last drives 3'b010; the last burst beat drives 3'b111.
- R5: With burst mode 2'b00 (linear), each beat's word address is the previous one plus one.
- R6: With burst mode 2'b01 (wrap of 4), address bits [1:0] count up modulo 4 and all higher bits are held.
- R7: With burst mode 2'b10 (wrap of 8), bits [2:0] count up modulo 8. With burst mode 2'b11 (wrap of 16), bits [3:0] count up modulo 16. Higher bits are held in both modes.
- R8: In the cycle after an acknowledge of a beat whose cycle type is not 3'b010, wb_cyc_o is low. A new command can be accepted in that same cycle.
- R9: done is high for exactly one cycle, the cycle after the last beat is acknowledged.
- R10: For reads, rd_valid is high in the cycle after each acknowledge, and rd_data holds the wb_dat_i value captured at that acknowledge.
- R11: For writes, the data of beat k (counting from 0) is the wr_data value presented while wr_beat equals k. wb_sel_o stays at cmd_sel for every beat, so only the selected byte lanes change in the target.
- R12: A command with a beat count of N (N of 1 or more) produces exactly N acknowledged beats. A count of 0 is handled as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_addr | input | AW | Start word address |
| cmd_beats | input | CW | Beat count (0 handled as 1) |
| cmd_bte | input | 2 | Burst mode: 00 linear, 01 wrap 4, 10 wrap 8, 11 wrap 16 |
| cmd_we | input | 1 | 1 for write, 0 for read |
| cmd_sel | input | DW/8 | Byte lanes used for every beat |
| wr_data | input | DW | Write data for the beat indexed by wr_beat |
| wr_beat | output | CW | Index of the write beat whose data is wanted on wr_data |
| busy | output | 1 | A transaction is open |
| done | output | 1 | One-cycle pulse after the last acknowledged beat |
| rd_valid | output | 1 | One-cycle strobe for a returned read beat |
| rd_data | output | DW | Returned read data |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_adr_o | output | AW | Word address |
| wb_we_o | output | 1 | Write enable |
| wb_sel_o | output | DW/8 | Byte selects |
| wb_dat_o | output | DW | Write data to the subordinate |
| wb_cti_o | output | 3 | Cycle type |
| wb_bte_o | output | 2 | Burst type |
| wb_ack_i | input | 1 | Beat acknowledge |
| wb_dat_i | input | DW | Read data from the subordinate |

## Verification
The bench builds the block with a 12-bit word address, a 32-bit data path and a 6-bit beat count. This allows bursts of up to 63 beats. With these settings, a 20-beat wrap-16 burst and a 10-beat wrap-8 burst each pass their wrap point, while the subordinate model decodes only the low 8 address bits. The subordinate inserts between zero and three wait states per beat. This keeps every beat held across several unacknowledged cycles and tests the hold rule as well as back-to-back commands issued the cycle after done.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLASSIC,
        ST_INCR,
        ST_FINAL
    } wbb_state_e;

    localparam logic [2:0] CTI_CLASSIC = 3'b000;
    localparam logic [2:0] CTI_INCR    = 3'b010;
    localparam logic [2:0] CTI_EOB     = 3'b111;

    localparam logic [1:0] BTE_LINEAR = 2'b00;
    localparam logic [1:0] BTE_WRAP4  = 2'b01;
    localparam logic [1:0] BTE_WRAP8  = 2'b10;
    localparam logic [1:0] BTE_WRAP16 = 2'b11;

endpackage

// File: rtl/wbb_addr_step.sv
module wbb_addr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur_adr,
    input  logic [1:0]    mode,
    output logic [AW-1:0] nxt_adr
);
    import wbb_pkg::*;

    localparam int WRAP_KINDS = 3;

    logic [AW-1:0] plus_one;
    logic [AW-1:0] wrapped [WRAP_KINDS];

    assign plus_one = cur_adr + AW'(1);

    // Wrap variant g keeps bits above (g+2) and counts the low (g+2) bits.
    for (genvar g = 0; g < WRAP_KINDS; g++) begin : g_wrap
        localparam int LB = g + 2;
        assign wrapped[g] = {cur_adr[AW-1:LB], plus_one[LB-1:0]};
    end

    always_comb begin
        unique case (mode)
            BTE_LINEAR: nxt_adr = plus_one;
            BTE_WRAP4:  nxt_adr = wrapped[0];
            BTE_WRAP8:  nxt_adr = wrapped[1];
            BTE_WRAP16: nxt_adr = wrapped[2];
            default:    nxt_adr = plus_one;
        endcase
    end

endmodule

// File: rtl/wbb_beat_count.sv
module wbb_beat_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_beats,
    input  logic          step,
    output logic [CW-1:0] left,
    output logic [CW-1:0] beat_idx,
    output logic          two_left
);
    always_ff @(posedge clk) begin
        if (rst) begin
            left     <= '0;
            beat_idx <= '0;
        end else if (load) begin
            left     <= (load_beats == '0) ? CW'(1) : load_beats;
            beat_idx <= CW'(1);
        end else if (step) begin
            left     <= left - CW'(1);
            beat_idx <= (left == CW'(1)) ? '0 : beat_idx + CW'(1);
        end
    end

    assign two_left = (left == CW'(2));

endmodule

// File: rtl/wbb_burst_initiator.sv
module wbb_burst_initiator #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [CW-1:0]   cmd_beats,
    input  logic [1:0]      cmd_bte,
    input  logic            cmd_we,
    input  logic [DW/8-1:0] cmd_sel,
    input  logic [DW-1:0]   wr_data,
    output logic [CW-1:0]   wr_beat,
    output logic            busy,
    output logic            done,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic            wb_cyc_o,
    output logic            wb_stb_o,
    output logic [AW-1:0]   wb_adr_o,
    output logic            wb_we_o,
    output logic [DW/8-1:0] wb_sel_o,
    output logic [DW-1:0]   wb_dat_o,
    output logic [2:0]      wb_cti_o,
    output logic [1:0]      wb_bte_o,
    input  logic            wb_ack_i,
    input  logic [DW-1:0]   wb_dat_i
);
    import wbb_pkg::*;

    localparam int SW = DW / 8;

    wbb_state_e    state_q, state_d;
    logic          accept, beat_ack, last_ack, two_left;
    logic [CW-1:0] left;
    logic [AW-1:0] adr_step;

    assign accept   = cmd_valid && (state_q == ST_IDLE);
    assign beat_ack = wb_stb_o && wb_ack_i;
    assign last_ack = beat_ack && ((state_q == ST_CLASSIC) || (state_q == ST_FINAL));

    wbb_beat_count #(.CW(CW)) u_count (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .load_beats (cmd_beats),
        .step       (beat_ack),
        .left       (left),
        .beat_idx   (wr_beat),
        .two_left   (two_left)
    );

    wbb_addr_step #(.AW(AW)) u_step (
        .cur_adr (wb_adr_o),
        .mode    (wb_bte_o),
        .nxt_adr (adr_step)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid)
                    state_d = (cmd_beats > CW'(1)) ? ST_INCR : ST_CLASSIC;
            end
            ST_CLASSIC, ST_FINAL: begin
                if (beat_ack) state_d = ST_IDLE;
            end
            ST_INCR: begin
                if (beat_ack) state_d = two_left ? ST_FINAL : ST_INCR;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        wb_cyc_o = 1'b0;
        wb_cti_o = CTI_CLASSIC;
        unique case (state_q)
            ST_IDLE:    begin wb_cyc_o = 1'b0; wb_cti_o = CTI_CLASSIC; end
            ST_CLASSIC: begin wb_cyc_o = 1'b1; wb_cti_o = CTI_CLASSIC; end
            ST_INCR:    begin wb_cyc_o = 1'b1; wb_cti_o = CTI_INCR;    end
            ST_FINAL:   begin wb_cyc_o = 1'b1; wb_cti_o = CTI_EOB;     end
            default:    begin wb_cyc_o = 1'b0; wb_cti_o = CTI_CLASSIC; end
        endcase
    end

    assign wb_stb_o = wb_cyc_o;
    assign busy     = wb_cyc_o;

    // Bus-side registers: loaded on accept, advanced only on an acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_adr_o <= '0;
            wb_we_o  <= 1'b0;
            wb_sel_o <= '0;
            wb_dat_o <= '0;
            wb_bte_o <= BTE_LINEAR;
        end else if (accept) begin
            wb_adr_o <= cmd_addr;
            wb_we_o  <= cmd_we;
            wb_sel_o <= cmd_sel;
            wb_dat_o <= wr_data;
            wb_bte_o <= cmd_bte;
        end else if (beat_ack && (state_q == ST_INCR)) begin
            wb_adr_o <= adr_step;
            if (wb_we_o) wb_dat_o <= wr_data;
        end
    end

    // User-side return path
    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            done     <= last_ack;
            rd_valid <= beat_ack && !wb_we_o;
            if (beat_ack && !wb_we_o) rd_data <= wb_dat_i;
        end
    end

    logic unused_ok;
    assign unused_ok = ^{left, SW};

endmodule

// File: rtl/wbb_burst_checker.sv
module wbb_burst_checker #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            done,
    input logic            rd_valid,
    input logic            wb_cyc_o,
    input logic            wb_stb_o,
    input logic [AW-1:0]   wb_adr_o,
    input logic            wb_we_o,
    input logic [DW/8-1:0] wb_sel_o,
    input logic [DW-1:0]   wb_dat_o,
    input logic [2:0]      wb_cti_o,
    input logic [1:0]      wb_bte_o,
    input logic            wb_ack_i
);
    logic beat_ack, pend;
    assign beat_ack = wb_cyc_o && wb_stb_o && wb_ack_i;
    assign pend     = wb_cyc_o && wb_stb_o && !wb_ack_i;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!wb_cyc_o && !wb_stb_o && !done && !rd_valid));

    assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (rst)
        pend |=> ($stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o) &&
                  $stable(wb_sel_o) && $stable(wb_cti_o) && $stable(wb_bte_o)));

    assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && wb_cti_o == 3'b010 && wb_bte_o == 2'b00)
        |=> (wb_adr_o == $past(wb_adr_o) + AW'(1)));

    assert_wrap4_step_R6: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && wb_cti_o == 3'b010 && wb_bte_o == 2'b01)
        |=> (wb_adr_o[1:0] == $past(wb_adr_o[1:0]) + 2'd1 &&
             wb_adr_o[AW-1:2] == $past(wb_adr_o[AW-1:2])));

    assert_wrap8_step_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && wb_cti_o == 3'b010 && wb_bte_o == 2'b10)
        |=> (wb_adr_o[2:0] == $past(wb_adr_o[2:0]) + 3'd1 &&
             wb_adr_o[AW-1:3] == $past(wb_adr_o[AW-1:3])));

    assert_wrap16_step_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && wb_cti_o == 3'b010 && wb_bte_o == 2'b11)
        |=> (wb_adr_o[3:0] == $past(wb_adr_o[3:0]) + 4'd1 &&
             wb_adr_o[AW-1:4] == $past(wb_adr_o[AW-1:4])));

    assert_cti_legal_R4: assert property (@(posedge clk) disable iff (rst)
        wb_cyc_o |-> (wb_cti_o == 3'b000 || wb_cti_o == 3'b010 || wb_cti_o == 3'b111));

    assert_cyc_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && wb_cti_o != 3'b010) |=> !wb_cyc_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && wb_cti_o != 3'b010) |=> done);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_read_return_R10: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && !wb_we_o) |=> rd_valid);

endmodule

bind wbb_burst_initiator wbb_burst_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .rd_valid (rd_valid),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_adr_o (wb_adr_o),
    .wb_we_o  (wb_we_o),
    .wb_sel_o (wb_sel_o),
    .wb_dat_o (wb_dat_o),
    .wb_cti_o (wb_cti_o),
    .wb_bte_o (wb_bte_o),
    .wb_ack_i (wb_ack_i)
);

// File: tb/wbb_burst_initiator_tb.sv
`timescale 1ns/1ps
module wbb_burst_initiator_tb;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int CW = 6;
    localparam int SW = DW / 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [CW-1:0] cmd_beats = '0;
    logic [1:0]    cmd_bte = '0;
    logic          cmd_we = 1'b0;
    logic [SW-1:0] cmd_sel = '0;
    logic [DW-1:0] wd_base = '0;
    logic [DW-1:0] wr_data;
    logic [CW-1:0] wr_beat;
    logic busy, done, rd_valid;
    logic [DW-1:0] rd_data;
    logic wb_cyc_o, wb_stb_o, wb_we_o, wb_ack_i;
    logic [AW-1:0] wb_adr_o;
    logic [SW-1:0] wb_sel_o;
    logic [DW-1:0] wb_dat_o, wb_dat_i;
    logic [2:0] wb_cti_o;
    logic [1:0] wb_bte_o;

    assign wr_data = wd_base + {{(DW-CW){1'b0}}, wr_beat};

    wbb_burst_initiator #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_beats(cmd_beats), .cmd_bte(cmd_bte), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
        .wr_data(wr_data), .wr_beat(wr_beat), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_data(rd_data), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
        .wb_adr_o(wb_adr_o), .wb_we_o(wb_we_o), .wb_sel_o(wb_sel_o), .wb_dat_o(wb_dat_o),
        .wb_cti_o(wb_cti_o), .wb_bte_o(wb_bte_o), .wb_ack_i(wb_ack_i), .wb_dat_i(wb_dat_i)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return 32'h5A000000 | (32'(i) * 32'h00010003);
    endfunction

    // Subordinate model with programmable wait states
    logic [DW-1:0] mem [0:255];
    int ws = 0;
    int wcnt = 0;
    assign wb_dat_i = mem[wb_adr_o[7:0]];
    always @(posedge clk) begin
        if (rst) begin
            wb_ack_i <= 1'b0;
            wcnt <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
        end else begin
            if (wb_cyc_o && wb_stb_o && !wb_ack_i) begin
                if (wcnt >= ws) begin wb_ack_i <= 1'b1; wcnt <= 0; end
                else wcnt <= wcnt + 1;
            end else wb_ack_i <= 1'b0;
            if (wb_cyc_o && wb_stb_o && wb_ack_i && wb_we_o)
                for (int b = 0; b < SW; b++)
                    if (wb_sel_o[b]) mem[wb_adr_o[7:0]][8*b +: 8] <= wb_dat_o[8*b +: 8];
        end
    end

    // Monitors
    logic [AW-1:0] l_adr [0:511];
    logic [2:0]    l_cti [0:511];
    logic [1:0]    l_bte [0:511];
    logic [DW-1:0] l_dat [0:511];
    logic [SW-1:0] l_sel [0:511];
    logic [DW-1:0] r_dat [0:511];
    int l_n = 0, r_n = 0;
    int stab_err = 0, drop_err = 0, done_err = 0;
    logic hold_q = 1'b0, drop_pend = 1'b0, done_q = 1'b0;
    logic [AW-1:0] p_adr; logic [DW-1:0] p_dat; logic [SW-1:0] p_sel;
    logic [2:0] p_cti; logic [1:0] p_bte; logic p_we;
    int cycles = 0;
    int tests = 0, fails = 0;

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst) begin
            if (hold_q && (wb_adr_o != p_adr || wb_dat_o != p_dat || wb_sel_o != p_sel ||
                           wb_cti_o != p_cti || wb_bte_o != p_bte || wb_we_o != p_we))
                stab_err = stab_err + 1;
            if (drop_pend && wb_cyc_o) drop_err = drop_err + 1;
            if (done && done_q) done_err = done_err + 1;
            if (wb_cyc_o && wb_stb_o && wb_ack_i) begin
                l_adr[l_n] = wb_adr_o; l_cti[l_n] = wb_cti_o; l_bte[l_n] = wb_bte_o;
                l_dat[l_n] = wb_dat_o; l_sel[l_n] = wb_sel_o;
                l_n = l_n + 1;
            end
            if (rd_valid) begin r_dat[r_n] = rd_data; r_n = r_n + 1; end
        end
        hold_q    = !rst && wb_cyc_o && wb_stb_o && !wb_ack_i;
        drop_pend = !rst && wb_cyc_o && wb_stb_o && wb_ack_i && (wb_cti_o != 3'b010);
        done_q    = done;
        p_adr = wb_adr_o; p_dat = wb_dat_o; p_sel = wb_sel_o;
        p_cti = wb_cti_o; p_bte = wb_bte_o; p_we = wb_we_o;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        if (cycles == 150000) begin
            tests = tests + 1; fails = fails + 1;
            $display("FAIL R12 watchdog: cycles=%0d expected < %0d", cycles, 150000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Shadow of the target memory, kept by the bench from the requirements
    logic [DW-1:0] sh [0:255];

    function automatic logic [AW-1:0] step_adr(input logic [AW-1:0] a, input logic [1:0] m);
        logic [AW-1:0] mask;
        if (m == 2'b00) return a + AW'(1);
        mask = AW'((1 << (int'(m) + 1)) - 1);
        return (a & ~mask) | ((a + AW'(1)) & mask);
    endfunction

    function automatic logic [2:0] exp_cti(input int k, input int nb);
        if (nb <= 1) return 3'b000;
        return (k == nb - 1) ? 3'b111 : 3'b010;
    endfunction

    // Issues one command, waits for done, leaves one more cycle for the monitors
    task automatic run_cmd(input logic [AW-1:0] a, input int beats, input logic [1:0] m,
                           input logic we, input logic [SW-1:0] sel, input logic [DW-1:0] base,
                           output int n0, output int r0);
        int guard;
        n0 = l_n; r0 = r_n;
        @(negedge clk);
        cmd_addr = a; cmd_beats = CW'(beats); cmd_bte = m; cmd_we = we; cmd_sel = sel;
        wd_base = base; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(wb_cyc_o && wb_stb_o && busy && wb_adr_o == a, "R2 start",
            {wb_cyc_o, busy, 18'b0, wb_adr_o}, {1'b1, 1'b1, 18'b0, a});
        guard = 0;
        while (!done && guard < 2000) begin @(negedge clk); guard++; end
        chk(done, "R9 done seen", 32'(done), 1);
        @(negedge clk);
    endtask

    // Checks the logged beats of one command against the expected sequence
    task automatic check_seq(input string req, input int n0, input int nb, input logic [AW-1:0] a0,
                             input logic [1:0] m, input logic we, input logic [SW-1:0] sel,
                             input logic [DW-1:0] base, input int r0);
        logic [AW-1:0] a = a0;
        int cnt = (nb == 0) ? 1 : nb;
        chk(l_n - n0 == cnt, {req, " R12 beat count"}, 32'(l_n - n0), 32'(cnt));
        for (int k = 0; k < cnt; k++) begin
            chk(l_adr[n0+k] == a, {req, " address"}, 32'(l_adr[n0+k]), 32'(a));
            chk(l_cti[n0+k] == exp_cti(k, cnt), "R4 cycle type", 32'(l_cti[n0+k]), 32'(exp_cti(k, cnt)));
            chk(l_bte[n0+k] == m, "R5 burst type out", 32'(l_bte[n0+k]), 32'(m));
            chk(l_sel[n0+k] == sel, "R11 byte select", 32'(l_sel[n0+k]), 32'(sel));
            if (we) begin
                chk(l_dat[n0+k] == base + DW'(k), "R11 write data", l_dat[n0+k], base + DW'(k));
                for (int b = 0; b < SW; b++)
                    if (sel[b]) sh[a[7:0]][8*b +: 8] = l_dat[n0+k][8*b +: 8];
            end else begin
                chk(r_dat[r0+k] == sh[a[7:0]], "R10 read data", r_dat[r0+k], sh[a[7:0]]);
            end
            a = step_adr(a, m);
        end
        if (!we) chk(r_n - r0 == cnt, "R10 read strobes", 32'(r_n - r0), 32'(cnt));
    endtask

    task automatic t_reset();
        chk(!wb_cyc_o && !wb_stb_o && !busy && !done && !rd_valid, "R1 reset idle",
            {27'b0, wb_cyc_o, wb_stb_o, busy, done, rd_valid}, 0);
    endtask

    task automatic t_single();
        int n0, r0;
        ws = 1;
        run_cmd(12'h010, 1, 2'b00, 1'b0, 4'hF, 0, n0, r0);
        check_seq("R12 single read", n0, 1, 12'h010, 2'b00, 1'b0, 4'hF, 0, r0);
        run_cmd(12'h011, 1, 2'b00, 1'b1, 4'b0101, 32'hCAFE0000, n0, r0);
        check_seq("R11 single write", n0, 1, 12'h011, 2'b00, 1'b1, 4'b0101, 32'hCAFE0000, r0);
        run_cmd(12'h011, 1, 2'b00, 1'b0, 4'hF, 0, n0, r0);
        check_seq("R11 partial readback", n0, 1, 12'h011, 2'b00, 1'b0, 4'hF, 0, r0);
    endtask

    task automatic t_linear();
        int n0, r0;
        ws = 2;
        run_cmd(12'h03E, 5, 2'b00, 1'b1, 4'hF, 32'h11110000, n0, r0);
        check_seq("R5 linear write", n0, 5, 12'h03E, 2'b00, 1'b1, 4'hF, 32'h11110000, r0);
        ws = 0;
        run_cmd(12'h03E, 5, 2'b00, 1'b0, 4'hF, 0, n0, r0);
        check_seq("R5 linear read", n0, 5, 12'h03E, 2'b00, 1'b0, 4'hF, 0, r0);
    endtask

    task automatic t_wrap4();
        int n0, r0;
        ws = 3;
        run_cmd(12'h412, 6, 2'b01, 1'b0, 4'hF, 0, n0, r0);
        check_seq("R6 wrap4 read", n0, 6, 12'h412, 2'b01, 1'b0, 4'hF, 0, r0);
        chk(l_adr[n0+2] == 12'h410, "R6 wrap point", 32'(l_adr[n0+2]), 32'h410);
    endtask

    task automatic t_wrap8_16();
        int n0, r0;
        ws = 1;
        run_cmd(12'h0A5, 10, 2'b10, 1'b1, 4'b0011, 32'h22220000, n0, r0);
        check_seq("R7 wrap8 write", n0, 10, 12'h0A5, 2'b10, 1'b1, 4'b0011, 32'h22220000, r0);
        chk(l_adr[n0+3] == 12'h0A0, "R7 wrap8 point", 32'(l_adr[n0+3]), 32'h0A0);
        run_cmd(12'h0A5, 10, 2'b10, 1'b0, 4'hF, 0, n0, r0);
        check_seq("R7 wrap8 read", n0, 10, 12'h0A5, 2'b10, 1'b0, 4'hF, 0, r0);
        ws = 0;
        run_cmd(12'h1F9, 20, 2'b11, 1'b0, 4'hF, 0, n0, r0);
        check_seq("R7 wrap16 read", n0, 20, 12'h1F9, 2'b11, 1'b0, 4'hF, 0, r0);
        chk(l_adr[n0+7] == 12'h1F0, "R7 wrap16 point", 32'(l_adr[n0+7]), 32'h1F0);
    endtask

    task automatic t_zero();
        int n0, r0;
        ws = 0;
        run_cmd(12'h020, 0, 2'b00, 1'b0, 4'hF, 0, n0, r0);
        check_seq("R12 zero count", n0, 0, 12'h020, 2'b00, 1'b0, 4'hF, 0, r0);
    endtask

    task automatic t_busy_ignore();
        int n0, r0, guard;
        ws = 2;
        n0 = l_n; r0 = r_n;
        @(negedge clk);
        cmd_addr = 12'h080; cmd_beats = 4; cmd_bte = 2'b00; cmd_we = 1'b0; cmd_sel = 4'hF;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_addr = 12'h300; cmd_beats = 1; cmd_we = 1'b1; wd_base = 32'hDEAD0000;
        @(negedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy && wb_adr_o != 12'h300, "R2 busy keeps command", 32'(wb_adr_o), 32'h080);
        guard = 0;
        while (!done && guard < 2000) begin @(negedge clk); guard++; end
        repeat (6) @(negedge clk);
        check_seq("R2 ignored while busy", n0, 4, 12'h080, 2'b00, 1'b0, 4'hF, 0, r0);
        chk(!busy && !wb_cyc_o, "R2 no extra transfer", 32'(busy), 0);
    endtask

    task automatic t_back_to_back();
        int n0, guard;
        ws = 0;
        n0 = l_n;
        @(negedge clk);
        cmd_addr = 12'h050; cmd_beats = 2; cmd_bte = 2'b00; cmd_we = 1'b0; cmd_sel = 4'hF;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        guard = 0;
        while (!done && guard < 2000) begin @(negedge clk); guard++; end
        chk(!wb_cyc_o, "R8 cyc low after last ack", 32'(wb_cyc_o), 0);
        cmd_addr = 12'h060; cmd_beats = 1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(wb_cyc_o && wb_adr_o == 12'h060, "R8 accept right after done", 32'(wb_adr_o), 32'h060);
        guard = 0;
        while (!done && guard < 2000) begin @(negedge clk); guard++; end
        @(negedge clk);
        chk(l_n - n0 == 3, "R12 back-to-back beats", 32'(l_n - n0), 3);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) sh[i] = pat(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_linear();
        t_wrap4();
        t_wrap8_16();
        t_zero();
        t_busy_ignore();
        t_back_to_back();
        chk(stab_err == 0, "R3 held until ack", 32'(stab_err), 0);
        chk(drop_err == 0, "R8 cyc dropped", 32'(drop_err), 0);
        chk(done_err == 0, "R9 done one cycle", 32'(done_err), 0);
        summary();
        $finish;
    end

endmodule